// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that takes its work from a chain of descriptors kept in memory. Software writes the address of the first descriptor into the pointer register and sets the run bit in the control/status word. The channel then reads the descriptor's four words, moves the commanded number of bytes from the source address to the target address, and follows the chain until it reaches a descriptor whose stop flag is set. Each descriptor carries its own increment, pacing, burst, width and interrupt settings.

Data moves in beats over a simple request/acknowledge memory port. A beat is one read followed by one write of the same size. A beat is one unit of the descriptor's width. When fewer bytes remain than one unit, the channel moves single bytes. When a peripheral request line paces the flow, the channel waits at each burst boundary until that line is high, then moves one burst. The final burst moves only the bytes that remain. Sticky flags in the control/status word drive a single interrupt output, and software clears them by writing ones.

Top module: `dma_chain_engine`

## Requirements
- R1: A descriptor is four words read at pointer+0, +4, +8 and +12. In order they are the next word, the source address, the target address and the command word. Bits 31:4 of the next word, with the low four bits zero, become the new pointer, which shows on `descPtrOut`.
- R2: When bit 0 of the next word is 1, the channel halts after that descriptor: run (bit 31) reads 0 and stopped (bit 3) reads 1. While stopped, the channel makes no memory request.
- R3: Command bit 31 makes the source address advance by each beat's size, and bit 30 does the same for the target address. When a bit is 0, that address is held.
- R4: Command bits 15:14 select the width: 1 is a byte, 2 a halfword, and 3 or 0 a word. Bits 12:0 give the byte count. When fewer bytes remain than one width unit, they move as single bytes. `memSize` gives log2 of the access size and is never 3.
- R5: Command bit 29 (source line) and bit 28 (target line) gate each burst on the request line. Bits 17:16 set the burst: 1 is 8 bytes, 2 is 16, 3 is 32, and 0 is one width unit. A final burst moves only the bytes that remain.
- R6: When a descriptor has been fetched, command bit 22 sets the start flag (status bit 1). When a descriptor completes, command bit 21 sets the end flag (status bit 2).
- R7: Writing 1 to status bits 2:0 clears those flags. `irqOut` is high while any of bits 2:0 is set, or while stopped (bit 3) and stop-interrupt enable (bit 29) are both set.
- R8: Writing run to 0 while busy halts the channel at the next burst or descriptor boundary, and the stopped bit then reads 1.
- R9: An error response on any fetch or data access sets the bus-error flag (bit 0), clears run and stops the channel.
- R10: After reset, the status word reads 0x00000008 and the pointer reads 0. A pointer write takes effect only while stopped.
- R11: Status bit 8 reads 1 while the channel is not stopped, the current command enables pacing on a request line, and that line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrCsr | input | 1 | Write strobe for the control/status word |
| cfgWrPtr | input | 1 | Write strobe for the descriptor pointer |
| cfgWrData | input | 32 | Write data for either register |
| csrOut | output | 32 | Current control/status word |
| descPtrOut | output | 32 | Current descriptor pointer |
| srcReq | input | 1 | Request line from the source peripheral |
| tgtReq | input | 1 | Request line from the target peripheral |
| memReq | output | 1 | Memory access request, held until acknowledged |
| memWe | output | 1 | 1 for write, 0 for read |
| memAddr | output | 32 | Byte address of the access |
| memSize | output | 2 | log2 of the access size in bytes |
| memWData | output | 32 | Write data, right-aligned |
| memRData | input | 32 | Read data, right-aligned, valid with acknowledge |
| memAck | input | 1 | Access complete |
| memErr | input | 1 | Error response, valid with acknowledge |
| irqOut | output | 1 | Channel interrupt |

## Verification
A wrong word index or a wrong pointer update shows up as wrong source or target addresses on the next data access, so the scoreboard catches it within a few cycles of the fetch. A wrong remaining-count or burst counter shows as a wrong beat size, an extra or missing write, or a burst that moves the wrong number of bytes for each request pulse. A mistake in the flags or the run state shows on `csrOut` and `irqOut` in the cycle after the event that should have changed them. The bench reads these outputs once the channel is stopped.

// File: rtl/dce_pkg.sv
package dce_pkg;
  localparam int WORD_W  = 32;
  localparam int LEN_W   = 13;
  localparam int BURST_W = 6;
  localparam int IDX_W   = 2;

  typedef enum logic [1:0] {PH_DESC, PH_READ, PH_WRITE} phase_e;

  typedef struct packed {
    phase_e phase;
    logic   clrIdx;
    logic   ldWord;
    logic   startBurst;
    logic   latchData;
    logic   advance;
    logic   nextDesc;
    logic   setStart;
    logic   setEnd;
    logic   setErr;
    logic   goIdle;
    logic   goBusy;
  } strobes_t;
endpackage

// File: rtl/dce_ctrl.sv
module dce_ctrl
  import dce_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     runBit,
  input  logic     idxLast,
  input  logic     remZero,
  input  logic     lastBeat,
  input  logic     stopFlag,
  input  logic     flowOk,
  input  logic     startEn,
  input  logic     endEn,
  input  logic     memAck,
  input  logic     memErr,
  output strobes_t strb,
  output logic     memReq,
  output logic     memWe
);
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_START, S_BURST, S_READ, S_WRITE, S_END
  } state_e;

  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strb   = '0;
    stateD = stateQ;
    memReq = 1'b0;
    memWe  = 1'b0;
    case (stateQ)
      S_IDLE: begin
        if (runBit) begin
          strb.goBusy = 1'b1;
          strb.clrIdx = 1'b1;
          stateD      = S_FETCH;
        end
      end
      S_FETCH: begin
        strb.phase = PH_DESC;
        memReq     = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strb.setErr = 1'b1;
            strb.goIdle = 1'b1;
            stateD      = S_IDLE;
          end else begin
            strb.ldWord = 1'b1;
            if (idxLast) stateD = S_START;
          end
        end
      end
      S_START: begin
        strb.setStart = startEn;
        stateD        = S_BURST;
      end
      S_BURST: begin
        if (remZero) begin
          stateD = S_END;
        end else if (!runBit) begin
          strb.goIdle = 1'b1;
          stateD      = S_IDLE;
        end else if (flowOk) begin
          strb.startBurst = 1'b1;
          stateD          = S_READ;
        end
      end
      S_READ: begin
        strb.phase = PH_READ;
        memReq     = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strb.setErr = 1'b1;
            strb.goIdle = 1'b1;
            stateD      = S_IDLE;
          end else begin
            strb.latchData = 1'b1;
            stateD         = S_WRITE;
          end
        end
      end
      S_WRITE: begin
        strb.phase = PH_WRITE;
        memReq     = 1'b1;
        memWe      = 1'b1;
        if (memAck) begin
          if (memErr) begin
            strb.setErr = 1'b1;
            strb.goIdle = 1'b1;
            stateD      = S_IDLE;
          end else begin
            strb.advance = 1'b1;
            stateD       = lastBeat ? S_BURST : S_READ;
          end
        end
      end
      S_END: begin
        strb.setEnd = endEn;
        if (stopFlag) begin
          strb.goIdle = 1'b1;
          stateD      = S_IDLE;
        end else begin
          strb.nextDesc = 1'b1;
          if (!runBit) begin
            strb.goIdle = 1'b1;
            stateD      = S_IDLE;
          end else begin
            strb.clrIdx = 1'b1;
            stateD      = S_FETCH;
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end
endmodule

// File: rtl/dce_datapath.sv
module dce_datapath
  import dce_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              cfgWrCsr,
  input  logic              cfgWrPtr,
  input  logic [WORD_W-1:0] cfgWrData,
  input  logic              srcReq,
  input  logic              tgtReq,
  input  logic [WORD_W-1:0] memRData,
  output logic [WORD_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [WORD_W-1:0] memWData,
  output logic [WORD_W-1:0] csrOut,
  output logic [WORD_W-1:0] descPtrOut,
  output logic              irqOut,
  output logic              runBit,
  output logic              idxLast,
  output logic              remZero,
  output logic              lastBeat,
  output logic              stopFlag,
  output logic              flowOk,
  output logic              startEn,
  output logic              endEn
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'((1 << IDX_W) - 1);

  logic [WORD_W-1:0]  descPtrQ, srcQ, tgtQ, dataQ;
  logic [WORD_W-5:0]  nextQ;
  logic               stopQ;
  logic               incSrcQ, incTgtQ, flowSrcQ, flowTgtQ, startIeQ, endIeQ;
  logic [1:0]         burstSelQ, widthSelQ;
  logic [LEN_W-1:0]   remQ;
  logic [BURST_W-1:0] burstLeftQ;
  logic [IDX_W-1:0]   idxQ;
  logic               runQ, stopIeQ, stoppedQ, endFlagQ, startFlagQ, errFlagQ;

  logic [LEN_W-1:0]   unitBytes, beatBytes;
  logic [BURST_W-1:0] burstBytes, beatShort;
  logic [1:0]         beatCode;
  logic               reqPend;
  logic               unusedBits;

  assign unusedBits = cfgWrData[3];

  // width unit and beat size
  always_comb begin
    case (widthSelQ)
      2'd1:    unitBytes = LEN_W'(1);
      2'd2:    unitBytes = LEN_W'(2);
      default: unitBytes = LEN_W'(4);
    endcase
    beatBytes = (remQ < unitBytes) ? LEN_W'(1) : unitBytes;
    beatShort = beatBytes[BURST_W-1:0];
    case (beatBytes[2:0])
      3'd1:    beatCode = 2'd0;
      3'd2:    beatCode = 2'd1;
      default: beatCode = 2'd2;
    endcase
    case (burstSelQ)
      2'd1:    burstBytes = BURST_W'(8);
      2'd2:    burstBytes = BURST_W'(16);
      2'd3:    burstBytes = BURST_W'(32);
      default: burstBytes = unitBytes[BURST_W-1:0];
    endcase
  end

  assign lastBeat = (beatBytes >= remQ) || (beatShort >= burstLeftQ);
  assign remZero  = (remQ == '0);
  assign idxLast  = (idxQ == LAST_IDX);
  assign stopFlag = stopQ;
  assign flowOk   = (!flowSrcQ || srcReq) && (!flowTgtQ || tgtReq);
  assign startEn  = startIeQ;
  assign endEn    = endIeQ;
  assign runBit   = runQ;
  assign reqPend  = !stoppedQ && ((flowSrcQ && srcReq) || (flowTgtQ && tgtReq));

  // memory request fields
  always_comb begin
    case (strb.phase)
      PH_DESC:  memAddr = descPtrQ + {{(WORD_W-IDX_W-2){1'b0}}, idxQ, 2'b00};
      PH_READ:  memAddr = srcQ;
      default:  memAddr = tgtQ;
    endcase
    memSize = (strb.phase == PH_DESC) ? 2'd2 : beatCode;
  end
  assign memWData = dataQ;

  // descriptor fields and transfer counters
  always_ff @(posedge clk) begin
    if (!rstN) begin
      descPtrQ   <= '0;
      nextQ      <= '0;
      stopQ      <= 1'b0;
      srcQ       <= '0;
      tgtQ       <= '0;
      dataQ      <= '0;
      incSrcQ    <= 1'b0;
      incTgtQ    <= 1'b0;
      flowSrcQ   <= 1'b0;
      flowTgtQ   <= 1'b0;
      startIeQ   <= 1'b0;
      endIeQ     <= 1'b0;
      burstSelQ  <= '0;
      widthSelQ  <= '0;
      remQ       <= '0;
      burstLeftQ <= '0;
      idxQ       <= '0;
    end else begin
      if (cfgWrPtr && stoppedQ) descPtrQ <= {cfgWrData[WORD_W-1:4], 4'b0000};
      if (strb.nextDesc)        descPtrQ <= {nextQ, 4'b0000};
      if (strb.clrIdx) idxQ <= '0;
      if (strb.ldWord) begin
        idxQ <= idxQ + 1'b1;
        case (idxQ)
          2'd0: begin
            nextQ <= memRData[WORD_W-1:4];
            stopQ <= memRData[0];
          end
          2'd1: srcQ <= memRData;
          2'd2: tgtQ <= memRData;
          default: begin
            incSrcQ   <= memRData[31];
            incTgtQ   <= memRData[30];
            flowSrcQ  <= memRData[29];
            flowTgtQ  <= memRData[28];
            startIeQ  <= memRData[22];
            endIeQ    <= memRData[21];
            burstSelQ <= memRData[17:16];
            widthSelQ <= memRData[15:14];
            remQ      <= memRData[LEN_W-1:0];
          end
        endcase
      end
      if (strb.startBurst) burstLeftQ <= burstBytes;
      if (strb.latchData)  dataQ <= memRData;
      if (strb.advance) begin
        remQ       <= remQ - beatBytes;
        burstLeftQ <= (burstLeftQ > beatShort) ? burstLeftQ - beatShort : '0;
        if (incSrcQ) srcQ <= srcQ + {{(WORD_W-LEN_W){1'b0}}, beatBytes};
        if (incTgtQ) tgtQ <= tgtQ + {{(WORD_W-LEN_W){1'b0}}, beatBytes};
      end
    end
  end

  // control/status word
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ       <= 1'b0;
      stopIeQ    <= 1'b0;
      stoppedQ   <= 1'b1;
      endFlagQ   <= 1'b0;
      startFlagQ <= 1'b0;
      errFlagQ   <= 1'b0;
    end else begin
      if (cfgWrCsr) begin
        runQ    <= cfgWrData[31];
        stopIeQ <= cfgWrData[29];
        if (cfgWrData[2]) endFlagQ   <= 1'b0;
        if (cfgWrData[1]) startFlagQ <= 1'b0;
        if (cfgWrData[0]) errFlagQ   <= 1'b0;
      end
      if (strb.setEnd)   endFlagQ   <= 1'b1;
      if (strb.setStart) startFlagQ <= 1'b1;
      if (strb.setErr)   errFlagQ   <= 1'b1;
      if (strb.goBusy)   stoppedQ   <= 1'b0;
      if (strb.goIdle) begin
        stoppedQ <= 1'b1;
        runQ     <= 1'b0;
      end
    end
  end

  assign csrOut = {runQ, 1'b0, stopIeQ, 20'b0, reqPend, 4'b0,
                   stoppedQ, endFlagQ, startFlagQ, errFlagQ};
  assign descPtrOut = descPtrQ;
  assign irqOut = endFlagQ || startFlagQ || errFlagQ || (stoppedQ && stopIeQ);
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dce_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrCsr,
  input  logic              cfgWrPtr,
  input  logic [WORD_W-1:0] cfgWrData,
  output logic [WORD_W-1:0] csrOut,
  output logic [WORD_W-1:0] descPtrOut,
  input  logic              srcReq,
  input  logic              tgtReq,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [1:0]        memSize,
  output logic [WORD_W-1:0] memWData,
  input  logic [WORD_W-1:0] memRData,
  input  logic              memAck,
  input  logic              memErr,
  output logic              irqOut
);
  strobes_t strb;
  logic runBit, idxLast, remZero, lastBeat, stopFlag, flowOk, startEn, endEn;

  dce_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .runBit(runBit), .idxLast(idxLast),
    .remZero(remZero), .lastBeat(lastBeat), .stopFlag(stopFlag),
    .flowOk(flowOk), .startEn(startEn), .endEn(endEn),
    .memAck(memAck), .memErr(memErr), .strb(strb),
    .memReq(memReq), .memWe(memWe)
  );

  dce_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgWrCsr(cfgWrCsr),
    .cfgWrPtr(cfgWrPtr), .cfgWrData(cfgWrData), .srcReq(srcReq),
    .tgtReq(tgtReq), .memRData(memRData), .memAddr(memAddr),
    .memSize(memSize), .memWData(memWData), .csrOut(csrOut),
    .descPtrOut(descPtrOut), .irqOut(irqOut), .runBit(runBit),
    .idxLast(idxLast), .remZero(remZero), .lastBeat(lastBeat),
    .stopFlag(stopFlag), .flowOk(flowOk), .startEn(startEn), .endEn(endEn)
  );
endmodule

// File: rtl/dma_chain_engine_checker.sv
module dma_chain_engine_checker (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memAck,
  input logic        memErr,
  input logic [1:0]  memSize,
  input logic [31:0] csrOut,
  input logic        irqOut
);
  // R7: interrupt follows the flags and the gated stop state
  a_r7_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == ((|csrOut[2:0]) || (csrOut[3] && csrOut[29])));

  // R9: an error response stops the channel and raises the bus-error flag
  a_r9_err_stops: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memAck && memErr) |=> (csrOut[0] && !csrOut[31] && csrOut[3]));

  // R2: no memory traffic while stopped
  a_r2_quiet_stopped: assert property (@(posedge clk) disable iff (!rstN)
    csrOut[3] |-> !memReq);

  // R8: entering the stopped state always leaves run cleared
  a_r8_run_low_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csrOut[3]) |-> !csrOut[31]);

  // R4: access size code is 1, 2 or 4 bytes only
  a_r4_size_legal: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memSize != 2'd3));
endmodule

bind dma_chain_engine dma_chain_engine_checker u_chk (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memAck(memAck), .memErr(memErr),
  .memSize(memSize), .csrOut(csrOut), .irqOut(irqOut)
);

// File: tb/dma_chain_engine_test.sv
module dma_chain_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  localparam logic [31:0] INC_S  = 32'h8000_0000;
  localparam logic [31:0] INC_T  = 32'h4000_0000;
  localparam logic [31:0] FLOW_S = 32'h2000_0000;
  localparam logic [31:0] ST_IE  = 32'h0040_0000;
  localparam logic [31:0] END_IE = 32'h0020_0000;
  localparam logic [31:0] BUR8   = 32'h0001_0000;
  localparam logic [31:0] WID1   = 32'h0000_4000;
  localparam logic [31:0] WID2   = 32'h0000_8000;
  localparam logic [31:0] WID4   = 32'h0000_C000;

  logic clk = 0, rstN = 0;
  logic cfgWrCsr = 0, cfgWrPtr = 0;
  logic [31:0] cfgWrData = 0;
  logic [31:0] csrOut, descPtrOut, memAddr, memWData;
  logic srcReq = 0, tgtReq = 0, memReq, memWe, irqOut;
  logic [1:0] memSize;
  logic [31:0] memRData = 0;
  logic memAck = 0, memErr = 0;

  dma_chain_engine uut (
    .clk(clk), .rstN(rstN), .cfgWrCsr(cfgWrCsr), .cfgWrPtr(cfgWrPtr),
    .cfgWrData(cfgWrData), .csrOut(csrOut), .descPtrOut(descPtrOut),
    .srcReq(srcReq), .tgtReq(tgtReq), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWData(memWData),
    .memRData(memRData), .memAck(memAck), .memErr(memErr), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { logic [31:0] a; logic [31:0] d; logic [1:0] s; } wr_t;
  wr_t   expQ[$];
  string tagQ[$];
  logic [31:0] rdLog[$];
  logic [7:0]  mem [0:4095];
  logic [31:0] errAddr = 32'hFFFF_FFFF;
  int errors = 0, checks = 0, byteCnt = 0, cycles = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rdBytes(input logic [31:0] a, input int n);
    logic [31:0] v = 0;
    for (int k = 0; k < n; k++) v[8*k +: 8] = mem[(a + k) & 32'hFFF];
    return v;
  endfunction

  // memory model and scoreboard monitor
  always @(negedge clk) begin
    memAck = 0;
    memErr = 0;
    if (memReq && rstN) begin
      automatic int n = 1 << memSize;
      memAck = 1;
      memErr = (memAddr == errAddr);
      if (memWe) begin
        for (int k = 0; k < n; k++) mem[(memAddr + k) & 32'hFFF] = memWData[8*k +: 8];
        byteCnt += n;
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected write", memAddr, 0);
        end else begin
          automatic wr_t e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          automatic logic [31:0] m = (n == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8*n)) - 1);
          check(memAddr == e.a, {t, " write address"}, memAddr, e.a);
          check(memSize == e.s, {t, " write size"}, {30'b0, memSize}, {30'b0, e.s});
          check((memWData & m) == e.d, {t, " write data"}, memWData & m, e.d);
        end
      end else begin
        rdLog.push_back(memAddr);
        memRData = rdBytes(memAddr, n);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic putDesc(input logic [31:0] at, input logic [31:0] nx, input logic [31:0] s,
                         input logic [31:0] t, input logic [31:0] c);
    logic [31:0] w [4];
    w[0] = nx; w[1] = s; w[2] = t; w[3] = c;
    for (int i = 0; i < 4; i++)
      for (int k = 0; k < 4; k++) mem[(at + 4*i + k) & 32'hFFF] = w[i][8*k +: 8];
  endtask

  // driver: push expected writes for a descriptor's data (or its first maxBeats beats)
  task automatic expCopy(input logic [31:0] s, input logic [31:0] t, input int len,
                         input int unit, input bit incS, input bit incT,
                         input int maxBeats, input string tag);
    int rem = len, beats = 0;
    while (rem > 0 && beats < maxBeats) begin
      automatic int n = (rem < unit) ? 1 : unit;
      automatic wr_t e;
      e.a = t;
      e.d = rdBytes(s, n);
      e.s = (n == 1) ? 2'd0 : (n == 2) ? 2'd1 : 2'd2;
      expQ.push_back(e);
      tagQ.push_back(tag);
      if (incS) s += n;
      if (incT) t += n;
      rem -= n;
      beats++;
    end
  endtask

  task automatic wrCsr(input logic [31:0] d);
    @(negedge clk); cfgWrCsr = 1; cfgWrData = d;
    @(negedge clk); cfgWrCsr = 0;
  endtask

  task automatic wrPtr(input logic [31:0] d);
    @(negedge clk); cfgWrPtr = 1; cfgWrData = d;
    @(negedge clk); cfgWrPtr = 0;
  endtask

  task automatic waitStop();
    int n = 0;
    do begin @(negedge clk); #1; n++; end while (!csrOut[3] && n < 2000);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic pulseSrc(input bit probe);
    @(negedge clk); srcReq = 1; #1;
    if (probe) check(csrOut[8] == 1'b1, "R11 pending with line high", csrOut, 32'h100);
    @(negedge clk); srcReq = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7 + 3);
    settle(3);
    rstN = 1;
    settle(1);

    // reset state
    check(csrOut == 32'h0000_0008, "R10 reset status", csrOut, 32'h8);
    check(descPtrOut == 0, "R10 reset pointer", descPtrOut, 0);
    check(irqOut == 0, "R7 reset irq", {31'b0, irqOut}, 0);

    // single word-wide descriptor
    putDesc(32'h100, 32'h1, 32'h400, 32'h800, INC_S | INC_T | END_IE | WID4 | 32'd16);
    expCopy(32'h400, 32'h800, 16, 4, 1, 1, 1000, "R3 single copy");
    rdLog.delete();
    wrPtr(32'h100);
    wrCsr(32'h8000_0000);
    waitStop();
    settle(2);
    check(rdLog.size() >= 4, "R1 fetch count", rdLog.size(), 4);
    for (int i = 0; i < 4 && i < rdLog.size(); i++)
      check(rdLog[i] == 32'h100 + 4*i, "R1 fetch order", rdLog[i], 32'h100 + 4*i);
    check(csrOut == 32'h0000_000C, "R2 R6 stop with end flag", csrOut, 32'hC);
    check(irqOut == 1, "R7 irq on end flag", {31'b0, irqOut}, 1);
    check(expQ.size() == 0, "R4 all beats seen", expQ.size(), 0);

    // write-one-to-clear
    wrCsr(32'h0000_0004);
    settle(1);
    check(csrOut == 32'h0000_0008, "R7 end flag cleared", csrOut, 32'h8);
    check(irqOut == 0, "R7 irq released", {31'b0, irqOut}, 0);

    // two-descriptor chain: halfword odd length, then bytes to a held target
    putDesc(32'h200, 32'h240, 32'h500, 32'h900, INC_S | INC_T | ST_IE | WID2 | 32'd5);
    putDesc(32'h240, 32'h1, 32'h580, 32'hA00, INC_S | END_IE | WID1 | 32'd3);
    expCopy(32'h500, 32'h900, 5, 2, 1, 1, 1000, "R4 halfword with byte tail");
    expCopy(32'h580, 32'hA00, 3, 1, 1, 0, 1000, "R3 held target");
    wrPtr(32'h200);
    wrCsr(32'h8000_0000);
    waitStop();
    settle(2);
    check(descPtrOut == 32'h240, "R1 pointer followed", descPtrOut, 32'h240);
    check(csrOut == 32'h0000_000E, "R6 start and end flags", csrOut, 32'hE);
    check(expQ.size() == 0, "R4 chain beats seen", expQ.size(), 0);
    wrCsr(32'h0000_0006);

    // paced bursts: 8 + 8 + 4 bytes
    putDesc(32'h300, 32'h1, 32'h700, 32'hC00, INC_S | INC_T | FLOW_S | BUR8 | WID4 | 32'd20);
    expCopy(32'h700, 32'hC00, 20, 4, 1, 1, 1000, "R5 paced copy");
    byteCnt = 0;
    wrPtr(32'h300);
    wrCsr(32'h8000_0000);
    settle(30);
    check(byteCnt == 0, "R5 waits for request", byteCnt, 0);
    check(csrOut[8] == 1'b0, "R11 no pending while line low", csrOut, 32'h0);
    pulseSrc(1);
    settle(30);
    check(byteCnt == 8, "R5 first burst", byteCnt, 8);
    pulseSrc(0);
    settle(30);
    check(byteCnt == 16, "R5 second burst", byteCnt, 16);
    pulseSrc(0);
    waitStop();
    settle(2);
    check(byteCnt == 20, "R5 short final burst", byteCnt, 20);
    check(csrOut == 32'h0000_0008, "R2 stopped after paced copy", csrOut, 32'h8);

    // run cleared mid-descriptor, pointer write while busy
    putDesc(32'h380, 32'h1, 32'h780, 32'hD00, INC_S | INC_T | FLOW_S | BUR8 | WID4 | 32'd32);
    expCopy(32'h780, 32'hD00, 32, 4, 1, 1, 2, "R8 partial copy");
    byteCnt = 0;
    wrPtr(32'h380);
    wrCsr(32'h8000_0000);
    settle(20);
    pulseSrc(0);
    settle(20);
    check(byteCnt == 8, "R8 one burst before halt", byteCnt, 8);
    wrPtr(32'hF00);
    settle(1);
    check(descPtrOut == 32'h380, "R10 pointer write ignored while busy", descPtrOut, 32'h380);
    wrCsr(32'h2000_0000);
    waitStop();
    settle(5);
    check(csrOut == 32'h2000_0008, "R8 halted at boundary", csrOut, 32'h2000_0008);
    check(irqOut == 1, "R7 stop interrupt", {31'b0, irqOut}, 1);
    check(byteCnt == 8, "R8 nothing moved after halt", byteCnt, 8);
    wrCsr(32'h0);
    settle(1);
    check(irqOut == 0, "R7 stop interrupt masked", {31'b0, irqOut}, 0);
    wrPtr(32'h3C0);
    settle(1);
    check(descPtrOut == 32'h3C0, "R10 pointer write while stopped", descPtrOut, 32'h3C0);

    // bus error on second data read
    putDesc(32'h3C0, 32'h1, 32'h600, 32'hB00, INC_S | INC_T | WID4 | 32'd8);
    expCopy(32'h600, 32'hB00, 8, 4, 1, 1, 1, "R9 write before error");
    errAddr = 32'h604;
    wrCsr(32'h8000_0000);
    waitStop();
    settle(2);
    check(csrOut == 32'h0000_0009, "R9 error flag and stop", csrOut, 32'h9);
    check(irqOut == 1, "R9 error interrupt", {31'b0, irqOut}, 1);
    check(expQ.size() == 0, "R9 no write after error", expQ.size(), 0);
    errAddr = 32'hFFFF_FFFF;
    wrCsr(32'h0000_0001);
    settle(1);
    check(csrOut == 32'h0000_0008, "R7 error flag cleared", csrOut, 32'h8);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule